// File: doc/BRIEF.md
# SD Card Data-Path Sequencer with Suspend

This block sequences the data side of multi-block transfers between a host and a card, one state per phase: sending a block, waiting for the card's CRC status token, receiving a block, and draining a suspended read. Bit serialization and CRC arithmetic live elsewhere; here they arrive as single-cycle strobes marking the end of a block and the arrival of a CRC token.

Suspend works as follows. The command side pulses `susp_ack` once the card has accepted a suspend command. A write in progress then finishes its current block, waits for that block's CRC token, and returns to Idle. A read in progress moves to a read-wait state. It leaves that state once the packet already in flight has ended and the receive FIFO has been emptied. No count of unsent blocks is kept. A resume is issued as a new transfer with a new block count. Clearing the enable input aborts any phase.

Top module: `sdp_susp_fsm`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `state_o` is Idle (0), `busy` is 0 and `done` is 0. The state encodings are Idle=0, write-send=1, CRC-wait=2, read-receive=3, read-wait=4.
- R2: In Idle, a `xfer_go` pulse with `dp_en` high moves the machine to write-send (when `xfer_rd`=0) or to read-receive (when `xfer_rd`=1) on the next edge. A `xfer_go` pulse with `dp_en` low is ignored.
- R3: Write-send moves to CRC-wait on `blk_end`. On `crc_tok`, CRC-wait returns to write-send while blocks remain, or goes to Idle after the last block. A `blk_count` of 0 is handled as a single block.
- R4: After a suspend has been accepted during a write, including a `susp_ack` in the same cycle as `crc_tok`, the next `crc_tok` in CRC-wait sends the machine to Idle, even if blocks remain.
- R5: A suspend accepted mid-block never shortens that block. Write-send stays in write-send until `blk_end`.
- R6: Read-receive stays in read-receive across block ends while blocks remain. It goes to Idle on the `blk_end` of the last block.
- R7: `susp_ack` in read-receive, unless it coincides with the last block's end, moves the machine to read-wait. Read-wait goes to Idle only after a `blk_end` has been seen, either on the entry cycle or while waiting, and `rx_empty` is high in a later cycle.
- R8: With `dp_en` low, every busy state goes to Idle on the next edge.
- R9: `susp_ack` in Idle has no effect. A transfer started after a suspend uses only its own `blk_count`.
- R10: `busy` is high exactly when `state_o` is not Idle. `done` is high for one cycle, in the first cycle of each stay in Idle that follows a busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dp_en | input | 1 | Data-path enable; low aborts to Idle |
| xfer_go | input | 1 | Start strobe, sampled in Idle |
| xfer_rd | input | 1 | Direction of the started transfer: 1 read, 0 write |
| blk_count | input | CNT_W | Number of blocks for the started transfer |
| susp_ack | input | 1 | Suspend accepted by the card (strobe from command side) |
| blk_end | input | 1 | Current block sent or received completely |
| crc_tok | input | 1 | CRC status token received for the written block |
| rx_empty | input | 1 | Receive FIFO is empty |
| state_o | output | 3 | Current state encoding |
| busy | output | 1 | High in every state other than Idle |
| done | output | 1 | One-cycle pulse on entry to Idle |

## Verification
The bench builds the block with `CNT_W`=4 and `SUSP_SAME_CYCLE`=1. The small counter keeps multi-block runs short while still exercising the zero-count case. The same-cycle option covers a suspend that lands on the CRC token edge. The vector walk places suspends at several points: mid-write-block, on the token edge, mid-read, and on a read block end. It also covers aborts from both directions, a suspend during Idle, and a fresh transfer after a suspend.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WSEND = 3'd1,
      ST_WCRC  = 3'd2,
      ST_RRECV = 3'd3,
      ST_RWAIT = 3'd4
   } sdp_state_e;
endpackage

// File: rtl/sdp_blk_cnt.sv
module sdp_blk_cnt #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             last
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] rem_q;

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_width
         $error("sdp_blk_cnt: CNT_W must lie in 1..16");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)              rem_q <= '0;
      else if (load)           rem_q <= load_val;
      else if (dec && !last)   rem_q <= rem_q - ONE;
   end

   // zero and one both mean "this is the final block"
   assign last = (rem_q <= ONE);
endmodule

// File: rtl/sdp_susp_hold.sv
module sdp_susp_hold #(
   parameter bit SAME_CYCLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic susp_ack,
   output logic susp_eff
);
   logic held_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                 held_q <= 1'b0;
      else if (!busy)             held_q <= 1'b0;
      else if (susp_ack)          held_q <= 1'b1;
   end

   generate
      if (SAME_CYCLE) begin : g_bypass
         assign susp_eff = held_q | (susp_ack & busy);
      end else begin : g_registered
         assign susp_eff = held_q;
      end
   endgenerate
endmodule

// File: rtl/sdp_susp_fsm.sv
module sdp_susp_fsm
   import sdp_pkg::*;
#(
   parameter int CNT_W           = 4,
   parameter bit SUSP_SAME_CYCLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dp_en,
   input  logic             xfer_go,
   input  logic             xfer_rd,
   input  logic [CNT_W-1:0] blk_count,
   input  logic             susp_ack,
   input  logic             blk_end,
   input  logic             crc_tok,
   input  logic             rx_empty,
   output logic [2:0]       state_o,
   output logic             busy,
   output logic             done
);
   sdp_state_e st_q, st_d;
   logic       last_blk, susp_eff, cnt_load, cnt_dec;
   logic       pkt_seen_q, done_q;

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("sdp_susp_fsm: CNT_W must be positive");
      end
   endgenerate

   assign busy     = (st_q != ST_IDLE);
   assign cnt_load = (st_q == ST_IDLE) && xfer_go && dp_en;
   assign cnt_dec  = dp_en && (((st_q == ST_WCRC) && crc_tok) ||
                               ((st_q == ST_RRECV) && blk_end));

   sdp_blk_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (blk_count),
      .dec      (cnt_dec),
      .last     (last_blk)
   );

   sdp_susp_hold #(.SAME_CYCLE(SUSP_SAME_CYCLE)) u_susp (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy     (busy),
      .susp_ack (susp_ack),
      .susp_eff (susp_eff)
   );

   always_comb begin
      st_d = st_q;
      if (st_q == ST_IDLE) begin
         if (xfer_go && dp_en) st_d = xfer_rd ? ST_RRECV : ST_WSEND;
      end else if (!dp_en) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_WSEND: if (blk_end) st_d = ST_WCRC;
            ST_WCRC:  if (crc_tok) st_d = (susp_eff || last_blk) ? ST_IDLE : ST_WSEND;
            ST_RRECV: begin
               if (blk_end && last_blk) st_d = ST_IDLE;
               else if (susp_eff)       st_d = ST_RWAIT;
            end
            ST_RWAIT: if (pkt_seen_q && rx_empty) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         pkt_seen_q <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= busy && (st_d == ST_IDLE);
         if (st_q == ST_RRECV && st_d == ST_RWAIT) pkt_seen_q <= blk_end;
         else if (st_q == ST_RWAIT && blk_end)     pkt_seen_q <= 1'b1;
      end
   end

   assign state_o = st_q;
   assign done    = done_q;

   // R8: losing the enable ends any busy phase at the next edge
   p_en_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !dp_en) |=> (state_o == 3'd0));

   // R5: a block being sent is never cut short
   p_wsend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WSEND && dp_en && !blk_end) |=> (st_q == ST_WSEND));

   // R4: accepted suspend ends the write at the CRC token
   p_crc_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WCRC && dp_en && crc_tok && susp_eff) |=> (st_q == ST_IDLE));

   // R7: read-wait holds while the FIFO still has data
   p_rwait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RWAIT && dp_en && !rx_empty) |=> (st_q == ST_RWAIT));

   // R10: done is a single-cycle pulse
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: done only on the first Idle cycle after a busy one
   p_done_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (st_q == ST_IDLE && $past(st_q) != ST_IDLE));

   // R9: Idle is left only through a start with enable
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && !(xfer_go && dp_en)) |=> (st_q == ST_IDLE));
endmodule

// File: tb/sdp_susp_fsm_tb.sv
module sdp_susp_fsm_tb_top;
   localparam int CNT_W = 4;
   localparam int NV    = 44;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dp_en = 1'b0, xfer_go = 1'b0, xfer_rd = 1'b0;
   logic susp_ack = 1'b0, blk_end = 1'b0, crc_tok = 1'b0, rx_empty = 1'b0;
   logic [CNT_W-1:0] blk_count = '0;
   logic [2:0] state_o;
   logic busy, done;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sdp_susp_fsm #(.CNT_W(CNT_W), .SUSP_SAME_CYCLE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .dp_en(dp_en), .xfer_go(xfer_go),
      .xfer_rd(xfer_rd), .blk_count(blk_count), .susp_ack(susp_ack),
      .blk_end(blk_end), .crc_tok(crc_tok), .rx_empty(rx_empty),
      .state_o(state_o), .busy(busy), .done(done)
   );

   // {go, rd, cnt[3:0], en, susp, blk_end, crc, rx_empty, exp_state[2:0], exp_busy, exp_done}
   localparam logic [15:0] VEC [NV] = '{
      16'b1_0_0010_1_0_0_0_0_001_1_0, // 0  write, 2 blocks
      16'b0_0_0000_1_0_1_0_0_010_1_0,
      16'b0_0_0000_1_0_0_1_0_001_1_0,
      16'b0_0_0000_1_0_1_0_0_010_1_0,
      16'b0_0_0000_1_0_0_1_0_000_0_1,
      16'b0_0_0000_1_0_0_0_0_000_0_0, // 5
      16'b1_0_0101_1_0_0_0_0_001_1_0, // 6  write, suspend mid-block
      16'b0_0_0000_1_1_0_0_0_001_1_0,
      16'b0_0_0000_1_0_0_0_0_001_1_0,
      16'b0_0_0000_1_0_1_0_0_010_1_0,
      16'b0_0_0000_1_0_0_1_0_000_0_1, // 10
      16'b0_0_0000_1_0_0_0_0_000_0_0,
      16'b0_0_0000_1_1_0_0_0_000_0_0, // 12 suspend while idle
      16'b1_0_0010_1_0_0_0_0_001_1_0,
      16'b0_0_0000_1_0_1_0_0_010_1_0,
      16'b0_0_0000_1_0_0_1_0_001_1_0, // 15
      16'b0_0_0000_1_0_1_0_0_010_1_0,
      16'b0_0_0000_1_0_0_1_0_000_0_1,
      16'b1_1_0010_1_0_0_0_0_011_1_0, // 18 read, 2 blocks
      16'b0_0_0000_1_0_1_0_0_011_1_0,
      16'b0_0_0000_1_0_1_0_0_000_0_1, // 20
      16'b1_1_0100_1_0_0_0_0_011_1_0, // 21 read suspend
      16'b0_0_0000_1_1_0_0_0_100_1_0,
      16'b0_0_0000_1_0_0_0_1_100_1_0,
      16'b0_0_0000_1_0_1_0_0_100_1_0,
      16'b0_0_0000_1_0_0_0_0_100_1_0, // 25
      16'b0_0_0000_1_0_0_0_1_000_0_1,
      16'b0_0_0000_1_0_0_0_0_000_0_0,
      16'b1_0_0011_1_0_0_0_0_001_1_0, // 28 enable drop, write
      16'b0_0_0000_1_1_0_0_0_001_1_0,
      16'b0_0_0000_0_0_0_0_0_000_0_1, // 30
      16'b0_0_0000_1_0_0_0_0_000_0_0,
      16'b1_1_0011_1_0_0_0_0_011_1_0, // 32 enable drop, read
      16'b0_0_0000_0_0_0_0_0_000_0_1,
      16'b1_0_0011_1_0_0_0_0_001_1_0, // 34 suspend on token edge
      16'b0_0_0000_1_0_1_0_0_010_1_0, // 35
      16'b0_0_0000_1_1_0_1_0_000_0_1,
      16'b1_0_0011_0_0_0_0_0_000_0_0, // 37 start without enable
      16'b1_0_0000_1_0_0_0_0_001_1_0, // 38 zero count
      16'b0_0_0000_1_0_1_0_0_010_1_0,
      16'b0_0_0000_1_0_0_1_0_000_0_1, // 40
      16'b1_1_0100_1_0_0_0_0_011_1_0, // 41 read suspend on block end
      16'b0_0_0000_1_1_1_0_0_100_1_0,
      16'b0_0_0000_1_0_0_0_1_000_0_1
   };

   function automatic string req_of(input int i);
      if (i == 0 || i == 18 || i == 21 || i == 37) return "R2";
      if (i <= 5 || (i >= 38 && i <= 40))          return "R3";
      if (i == 7 || i == 8)                        return "R5";
      if (i <= 11 || (i >= 34 && i <= 36))         return "R4";
      if (i <= 17)                                 return "R9";
      if (i <= 20)                                 return "R6";
      if (i <= 27 || i >= 41)                      return "R7";
      return "R8";
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [15:0] v);
      xfer_go   = v[15];
      xfer_rd   = v[14];
      blk_count = v[13:10];
      dp_en     = v[9];
      susp_ack  = v[8];
      blk_end   = v[7];
      crc_tok   = v[6];
      rx_empty  = v[5];
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", "state in reset", int'(state_o), 0);
      check("R1", "busy in reset", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "state after reset", int'(state_o), 0);
      check("R1", "done after reset", int'(done), 0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i]);
         @(negedge clk);
         check(req_of(i), $sformatf("state v%0d", i), int'(state_o), int'(VEC[i][4:2]));
         check("R10", $sformatf("busy v%0d", i), int'(busy), int'(VEC[i][1]));
         check("R10", $sformatf("done v%0d", i), int'(done), int'(VEC[i][0]));
      end

      // R1: reset in the middle of a write returns to Idle with no done
      drive(16'b1_0_0100_1_0_0_0_0_000_0_0);
      @(negedge clk);
      check("R2", "write started", int'(state_o), 1);
      drive(16'b0);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", "state after mid reset", int'(state_o), 0);
      check("R1", "done after mid reset", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "busy after release", int'(busy), 0);

      // R7: read-wait with FIFO never draining stays put
      drive(16'b1_1_0100_1_0_0_0_0_000_0_0);
      @(negedge clk);
      drive(16'b0_0_0000_1_1_1_0_0_000_0_0);
      @(negedge clk);
      drive(16'b0_0_0000_1_0_0_0_0_000_0_0);
      repeat (5) @(negedge clk);
      check("R7", "read-wait hold", int'(state_o), 4);
      drive(16'b0_0_0000_1_0_0_0_1_000_0_0);
      @(negedge clk);
      check("R7", "read-wait exit", int'(state_o), 0);
      check("R10", "done on read-wait exit", int'(done), 1);

      finish_run();
   end
endmodule